// File: doc/BRIEF.md
# Synchronous Burst SRAM Control Front End

This block is the clocked control and address path of a pipelined burst static RAM whose words are split into byte lanes. Three chip selects decide whether the device takes part in a cycle. Either of two address strobes can open an access: one comes from a processor and one from a memory controller. The start address is split into a fixed upper part and a 2-bit burst counter. An advance input steps that counter through a four-word linear burst. The counter wraps inside the aligned group of four words.

Write enables are resolved per byte lane. A global write stores every lane. Otherwise the byte-write enable qualifies the per-lane selects. An access opened by the processor strobe is always a read. Read data is registered, so it appears one clock after the address phase. A data-drive enable, gated by an asynchronous active-low output enable, tells the pad ring when to drive the bus. That enable is held off for the first read clock after the device was deselected.

There is no flow control at this edge. Every cycle is accepted, so there is no valid/ready handshake and no back-pressure. A caller paces bursts with the strobes and the advance input alone. The storage is a small parameterised register file that is cleared at reset.

Top module: `burst_sram_ctrl`

## Requirements
- R1: An access begins only when sel_a_n=0, sel_b=1 and sel_c_n=0 are sampled together with an accepted strobe. An accepted strobe with any other select combination deselects the device. While deselected, lane_we stays 4'b0000 and drive_en stays 0.
- R2: An accepted strobe on a selected device loads addr_i. word_addr equals that value after the same rising edge.
- R3: If both strobes are low, the processor strobe governs. An access it opens is a read: lane_we is 0 for that cycle, even with all_wr_n or lane_en_n low.
- R4: The processor strobe is ignored when sel_a_n is sampled high. With strb_ctl_n high, the cycle then acts as a continuation of the running burst.
- R5: In a continuation cycle with adv_n low, the low 2 bits of word_addr increment modulo 4. The upper bits are unchanged.
- R6: In a continuation cycle with adv_n high, word_addr holds its value.
- R7: lane_we bit i controls bits 8i+7..8i of the word. all_wr_n=0 gives 4'b1111. Otherwise, lane_en_n=0 gives ~lane_sel_n. Otherwise lane_we is 4'b0000. lane_we shows the strobes of the access at word_addr.
- R8: An access with lane_we=0 is a read. Its data is on rdata one clock after its word_addr phase and reflects all earlier byte-masked writes.
- R9: drive_en is 1 only during a read data phase while out_en_n is low. It follows out_en_n without waiting for a clock.
- R10: The first read data phase of an access opened directly from the deselected state (or from reset) keeps drive_en at 0 whatever out_en_n is.
- R11: After reset the device is deselected, lane_we is 0, drive_en is 0 and every word of the array reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 6 | Word address presented with a strobe |
| strb_cpu_n | input | 1 | Processor address strobe, active low |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | Chip select A, active low; also gates the processor strobe |
| sel_b | input | 1 | Chip select B, active high |
| sel_c_n | input | 1 | Chip select C, active low |
| lane_sel_n | input | 4 | Per-lane write selects, active low |
| lane_en_n | input | 1 | Byte-write qualifier, active low |
| all_wr_n | input | 1 | Global write, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | 32 | Write data for the current access |
| rdata | output | 32 | Registered read data |
| drive_en | output | 1 | Data bus drive enable |
| word_addr | output | 6 | Internal word address of the current access |
| lane_we | output | 4 | Byte-lane write strobes of the current access |

## Verification
The bench aims at the burst counter wrap. A counter that carried into the upper bits would leave the four-word group after the third step. It drives both strobes low together with a global write. A design that let the controller strobe win would store data on what must be a read. It holds the processor strobe low with select A high during a burst. A design that did not ignore it would restart or deselect instead of stepping. It also checks the masked first read after deselection and toggles out_en_n between clock edges, where a registered enable would lag a cycle. A long stretch of randomly mixed cycles, compared against a behavioural memory model with byte-masked writes, catches lane mapping and read-pipeline offsets.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_DESEL = 2'd2
  } step_e;
endpackage

// File: rtl/sbs_select.sv
module sbs_select
  import sbs_pkg::*;
(
  input  logic  strb_cpu_n,
  input  logic  strb_ctl_n,
  input  logic  sel_a_n,
  input  logic  sel_b,
  input  logic  sel_c_n,
  output step_e step_o,
  output logic  cpu_take_o
);
  logic chip_on;
  logic cpu_req;
  logic ctl_req;

  assign chip_on = !sel_a_n && sel_b && !sel_c_n;
  // processor strobe only counts while select A is low
  assign cpu_req = !strb_cpu_n && !sel_a_n;
  assign ctl_req = !strb_ctl_n;

  always_comb begin
    step_o     = ST_HOLD;
    cpu_take_o = 1'b0;
    if (cpu_req) begin
      step_o     = chip_on ? ST_LOAD : ST_DESEL;
      cpu_take_o = chip_on;
    end else if (ctl_req) begin
      step_o = chip_on ? ST_LOAD : ST_DESEL;
    end
  end
endmodule

// File: rtl/sbs_burst_addr.sv
module sbs_burst_addr
  import sbs_pkg::*;
#(
  parameter int AW = 6,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  step_e         step_i,
  input  logic [AW-1:0] addr_i,
  input  logic          adv_n_i,
  output logic [AW-1:0] word_addr_o,
  output logic          active_o,
  output logic          first_o
);
  localparam int UW = AW - CW;

  logic [UW-1:0] base_hi;
  logic [CW-1:0] cnt;
  logic          active_q;
  logic          first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_hi  <= '0;
      cnt      <= '0;
      active_q <= 1'b0;
      first_q  <= 1'b0;
    end else begin
      case (step_i)
        ST_LOAD: begin
          base_hi  <= addr_i[AW-1:CW];
          cnt      <= addr_i[CW-1:0];
          active_q <= 1'b1;
          first_q  <= !active_q;
        end
        ST_DESEL: begin
          active_q <= 1'b0;
          first_q  <= 1'b0;
        end
        default: begin
          first_q <= 1'b0;
          if (active_q && !adv_n_i) cnt <= cnt + CW'(1);
        end
      endcase
    end
  end

  assign word_addr_o = {base_hi, cnt};
  assign active_o    = active_q;
  assign first_o     = first_q;

  // R2: a load shows the strobed address after the edge
  a_r2_load_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i == ST_LOAD) |=> (word_addr_o == $past(addr_i)));
  // R5: upper bits never move during a continuation
  a_r5_upper_held: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i == ST_HOLD) |=> $stable(base_hi));
  // R5: linear step wraps within the group
  a_r5_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i == ST_HOLD && active_q && !adv_n_i) |=> (cnt == $past(cnt) + CW'(1)));
  // R6: no advance keeps the counter
  a_r6_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i == ST_HOLD && adv_n_i) |=> $stable(cnt));
endmodule

// File: rtl/sbs_write_lanes.sv
module sbs_write_lanes #(
  parameter int NB = 4
) (
  input  logic          allow_i,
  input  logic          all_wr_n,
  input  logic          lane_en_n,
  input  logic [NB-1:0] lane_sel_n,
  output logic [NB-1:0] lane_we_o
);
  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign lane_we_o[i] = allow_i && (!all_wr_n || (!lane_en_n && !lane_sel_n[i]));
  end
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int BW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr_i,
  input  logic [NB-1:0]    lane_we_i,
  input  logic [NB*BW-1:0] wdata_i,
  input  logic             rd_i,
  output logic [NB*BW-1:0] rdata_o,
  output logic             rvalid_o
);
  localparam int DW    = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] bit_mask;

  for (genvar i = 0; i < NB; i++) begin : g_mask
    assign bit_mask[i*BW +: BW] = {BW{lane_we_i[i]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      if (|lane_we_i) mem[addr_i] <= (mem[addr_i] & ~bit_mask) | (wdata_i & bit_mask);
      if (rd_i) rdata_o <= mem[addr_i];
      rvalid_o <= rd_i;
    end
  end

  // R8: a write and a read never share one access
  a_r8_rd_or_wr: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_i && (|lane_we_i)));
endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import sbs_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int BW = 8,
  parameter int CW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr_i,
  input  logic             strb_cpu_n,
  input  logic             strb_ctl_n,
  input  logic             adv_n,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic [NB-1:0]    lane_sel_n,
  input  logic             lane_en_n,
  input  logic             all_wr_n,
  input  logic             out_en_n,
  input  logic [NB*BW-1:0] wdata,
  output logic [NB*BW-1:0] rdata,
  output logic             drive_en,
  output logic [AW-1:0]    word_addr,
  output logic [NB-1:0]    lane_we
);
  localparam int DW = NB * BW;

  step_e         step;
  logic          cpu_take;
  logic          active;
  logic          first;
  logic          nxt_active;
  logic          allow_wr;
  logic [NB-1:0] lane_we_nxt;
  logic [NB-1:0] lane_we_q;
  logic [DW-1:0] wdata_q;
  logic          rd_q;
  logic          rfirst_q;
  logic          rvalid;

  sbs_select u_select (
    .strb_cpu_n (strb_cpu_n),
    .strb_ctl_n (strb_ctl_n),
    .sel_a_n    (sel_a_n),
    .sel_b      (sel_b),
    .sel_c_n    (sel_c_n),
    .step_o     (step),
    .cpu_take_o (cpu_take)
  );

  sbs_burst_addr #(.AW(AW), .CW(CW)) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_i      (step),
    .addr_i      (addr_i),
    .adv_n_i     (adv_n),
    .word_addr_o (word_addr),
    .active_o    (active),
    .first_o     (first)
  );

  assign nxt_active = (step == ST_LOAD) || (step == ST_HOLD && active);
  assign allow_wr   = nxt_active && !cpu_take;

  sbs_write_lanes #(.NB(NB)) u_lanes (
    .allow_i    (allow_wr),
    .all_wr_n   (all_wr_n),
    .lane_en_n  (lane_en_n),
    .lane_sel_n (lane_sel_n),
    .lane_we_o  (lane_we_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_we_q <= '0;
      wdata_q   <= '0;
      rd_q      <= 1'b0;
      rfirst_q  <= 1'b0;
    end else begin
      lane_we_q <= lane_we_nxt;
      wdata_q   <= wdata;
      rd_q      <= nxt_active && (lane_we_nxt == '0);
      rfirst_q  <= first && rd_q;
    end
  end

  sbs_array #(.AW(AW), .NB(NB), .BW(BW)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_i    (word_addr),
    .lane_we_i (lane_we_q),
    .wdata_i   (wdata_q),
    .rd_i      (rd_q),
    .rdata_o   (rdata),
    .rvalid_o  (rvalid)
  );

  assign lane_we  = lane_we_q;
  assign drive_en = rvalid && !rfirst_q && !out_en_n;

  // R1: deselected device writes nothing
  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (lane_we_q == '0));
  // R3: processor-opened access is a read
  a_r3_cpu_load_reads: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_take |=> (lane_we_q == '0));
  // R8: read address phase is followed by a data phase
  a_r8_read_lands: assert property (@(posedge clk) disable iff (!rst_n)
    rd_q |=> rvalid);
  // R10: first read after deselection is not driven
  a_r10_first_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (first && rd_q) |=> !drive_en);
endmodule

// File: tb/tb_burst_sram_ctrl.sv
module tb_burst_sram_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr_i = '0;
  logic        strb_cpu_n = 1'b1, strb_ctl_n = 1'b1, adv_n = 1'b1;
  logic        sel_a_n = 1'b0, sel_b = 1'b1, sel_c_n = 1'b0;
  logic [3:0]  lane_sel_n = 4'hF;
  logic        lane_en_n = 1'b1, all_wr_n = 1'b1, out_en_n = 1'b1;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        drive_en;
  logic [5:0]  word_addr;
  logic [3:0]  lane_we;

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R11";

  burst_sram_ctrl dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .strb_cpu_n(strb_cpu_n),
    .strb_ctl_n(strb_ctl_n), .adv_n(adv_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .lane_sel_n(lane_sel_n), .lane_en_n(lane_en_n),
    .all_wr_n(all_wr_n), .out_en_n(out_en_n), .wdata(wdata), .rdata(rdata),
    .drive_en(drive_en), .word_addr(word_addr), .lane_we(lane_we)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [31:0] mmem [64];
  logic        m_active = 1'b0, m_first = 1'b0, m_rd = 1'b0;
  logic        m_rvalid = 1'b0, m_rfirst = 1'b0;
  logic [5:0]  m_addr = '0;
  logic [3:0]  m_be = '0;
  logic [31:0] m_wdata = '0, m_rdata = '0;

  always @(posedge clk) begin
    logic chip, cpu, ctl, take_cpu;
    logic [3:0] be;
    if (!rst_n) begin
      for (int w = 0; w < 64; w++) mmem[w] = '0;
      m_active = 0; m_first = 0; m_rd = 0; m_rvalid = 0; m_rfirst = 0;
      m_be = 0; m_rdata = 0; m_addr = 0;
    end else begin
      for (int i = 0; i < 4; i++)
        if (m_be[i]) mmem[m_addr][8*i +: 8] = m_wdata[8*i +: 8];
      m_rvalid = m_rd;
      m_rfirst = m_first && m_rd;
      if (m_rd) m_rdata = mmem[m_addr];
      chip = !sel_a_n && sel_b && !sel_c_n;
      cpu  = !strb_cpu_n && !sel_a_n;
      ctl  = !strb_ctl_n;
      take_cpu = 0;
      if (cpu || ctl) begin
        if (chip) begin
          m_first = !m_active; m_active = 1; m_addr = addr_i; take_cpu = cpu;
        end else begin
          m_active = 0; m_first = 0;
        end
      end else begin
        m_first = 0;
        if (m_active && !adv_n) m_addr = {m_addr[5:2], m_addr[1:0] + 2'd1};
      end
      be = 4'h0;
      if (m_active && !take_cpu) begin
        if (!all_wr_n) be = 4'hF;
        else if (!lane_en_n) be = ~lane_sel_n;
      end
      m_be = be; m_wdata = wdata; m_rd = m_active && (be == 4'h0);
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare_model();
    logic exp_drive;
    exp_drive = m_rvalid && !m_rfirst && !out_en_n;
    chk("R7", "lane_we", 32'(lane_we), 32'(m_be));
    chk("R9", "drive_en", 32'(drive_en), 32'(exp_drive));
    if (m_active) chk(cur_req, "word_addr", 32'(word_addr), 32'(m_addr));
    if (exp_drive) chk("R8", "rdata", rdata, m_rdata);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_model();
  endtask

  task automatic quiet();
    strb_cpu_n = 1; strb_ctl_n = 1; adv_n = 1;
    sel_a_n = 0; sel_b = 1; sel_c_n = 0;
    all_wr_n = 1; lane_en_n = 1; lane_sel_n = 4'hF;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", "drive_en at reset", 32'(drive_en), 32'd0);
    chk("R11", "lane_we at reset", 32'(lane_we), 32'd0);
    rst_n = 1;

    // R7: lane strobes, controller-opened burst at word 8
    cur_req = "R2";
    quiet(); strb_ctl_n = 0; addr_i = 6'd8; all_wr_n = 0; wdata = 32'hA1B2C3D4;
    tick();
    chk("R2", "word_addr after ctl load", 32'(word_addr), 32'd8);
    chk("R7", "global write lanes", 32'(lane_we), 32'hF);
    quiet(); adv_n = 0; lane_en_n = 0; lane_sel_n = 4'b1010; wdata = 32'h11223344;
    cur_req = "R5";
    tick();
    chk("R7", "masked lanes", 32'(lane_we), 32'b0101);
    quiet(); adv_n = 0; lane_en_n = 1; lane_sel_n = 4'b0000;
    tick();
    chk("R7", "selects without qualifier", 32'(lane_we), 32'd0);
    quiet(); adv_n = 0; all_wr_n = 0; lane_en_n = 1; wdata = 32'hCAFEF00D;
    tick();

    // R1: strobe while select B low deselects, even with a write requested
    cur_req = "R1";
    quiet(); strb_ctl_n = 0; sel_b = 0; all_wr_n = 0;
    tick();
    chk("R1", "lane_we while off", 32'(lane_we), 32'd0);
    quiet(); all_wr_n = 0; out_en_n = 0;
    tick();
    chk("R1", "no write while off", 32'(lane_we), 32'd0);
    chk("R1", "no drive while off", 32'(drive_en), 32'd0);

    // R10: processor read right after deselection, write inputs ignored
    cur_req = "R2";
    quiet(); strb_cpu_n = 0; addr_i = 6'd8; all_wr_n = 0;
    tick();
    chk("R3", "cpu load ignores write", 32'(lane_we), 32'd0);
    chk("R2", "word_addr after cpu load", 32'(word_addr), 32'd8);
    quiet(); adv_n = 0;
    tick();
    chk("R10", "first read masked", 32'(drive_en), 32'd0);
    quiet(); adv_n = 0;
    tick();
    chk("R8", "second read driven", 32'(drive_en), 32'd1);
    chk("R8", "rdata of word 9", rdata, 32'h00220044);

    // R9: asynchronous output enable during a data phase
    out_en_n = 1; #1;
    chk("R9", "release on oe high", 32'(drive_en), 32'd0);
    out_en_n = 0; #1;
    chk("R9", "drive on oe low", 32'(drive_en), 32'd1);

    // R5: wrap inside the group from word 10
    cur_req = "R5";
    quiet(); strb_ctl_n = 0; addr_i = 6'd10;
    tick();
    quiet(); adv_n = 0; tick(); chk("R5", "step to 11", 32'(word_addr), 32'd11);
    quiet(); adv_n = 0; tick(); chk("R5", "wrap to 8", 32'(word_addr), 32'd8);
    quiet(); adv_n = 0; tick(); chk("R5", "step to 9", 32'(word_addr), 32'd9);

    // R6: hold
    cur_req = "R6";
    quiet(); tick(); chk("R6", "hold at 9", 32'(word_addr), 32'd9);
    chk("R6", "hold reads again", 32'(lane_we), 32'd0);

    // R3: both strobes low with a global write
    cur_req = "R3";
    quiet(); strb_cpu_n = 0; strb_ctl_n = 0; addr_i = 6'd20; all_wr_n = 0;
    tick();
    chk("R3", "both strobes load", 32'(word_addr), 32'd20);
    chk("R3", "both strobes no write", 32'(lane_we), 32'd0);

    // R4: processor strobe with select A high continues the burst
    cur_req = "R4";
    quiet(); strb_cpu_n = 0; sel_a_n = 1; adv_n = 0;
    tick();
    chk("R4", "burst continues", 32'(word_addr), 32'd21);

    // mixed traffic against the model
    cur_req = "R5";
    for (int k = 0; k < 3000; k++) begin
      strb_cpu_n = ($urandom % 6) != 0;
      strb_ctl_n = ($urandom % 5) != 0;
      adv_n      = ($urandom % 3) == 0;
      sel_a_n    = ($urandom % 10) == 0;
      sel_b      = ($urandom % 10) != 0;
      sel_c_n    = ($urandom % 12) == 0;
      all_wr_n   = ($urandom % 6) != 0;
      lane_en_n  = ($urandom % 3) == 0;
      lane_sel_n = 4'($urandom);
      out_en_n   = ($urandom % 4) == 0;
      addr_i     = 6'($urandom);
      wdata      = $urandom;
      tick();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule